// File: doc/BRIEF.md
# Switch Fault Protection Supervisor

This block guards a power switch using only digital event inputs. It takes a switch-on command, a current-comparator trip, an overvoltage-clamp activity flag and an undervoltage flag. From these it produces a gated switch enable and a registered two-bit status code. Three timing checks can latch a sticky switch error:

- a comparator trip that comes too soon after turn-on, which points to a shorted winding;
- an on-time that runs past its maximum, which points to a high-impedance path;
- a clamp that stays active past its blanking window, which points to an open secondary.

Only a reset clears the latched error.

Undervoltage does not latch. While it is present, switching stops and the status reports the undervoltage code, even when a switch error is already latched. When undervoltage goes away, one of two things happens. Switching resumes, or the latched error code shows and switching stays off.

All time windows are given as clock-cycle counts. At 100 MHz the defaults are 85 cycles (short window), 5000 cycles (maximum on-time) and 20 cycles (clamp blanking).

The controller is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Switch off |
| `ST_BLANK` | Switch on, still inside the short window |
| `ST_ON` | Switch on, past the short window |
| `ST_TRIPPED` | Sticky switch error |

Its transitions are:

- **turn-on**: `ST_IDLE` to `ST_BLANK`, or straight to `ST_ON` when the short window is one cycle.
- **window-done**: `ST_BLANK` to `ST_ON`.
- **turn-off**: `ST_BLANK` or `ST_ON` back to `ST_IDLE`.
- **trip**: any other state to `ST_TRIPPED`.
- **reset**: back to `ST_IDLE`.

Top module: `sfp_supervisor`

## Requirements
- R1: A comparator trip while the switch is enabled, in on-cycle k (k=0 is the first enabled cycle) with k < SHORT_CYC, latches the switch error.
- R2: A comparator trip in on-cycle k >= SHORT_CYC is a normal event and latches nothing.
- R3: An enabled on-period of exactly MAXON_CYC cycles is accepted. The switch error latches in on-cycle MAXON_CYC, the first cycle that exceeds the limit.
- R4: A clamp-active run of up to CLAMP_CYC consecutive cycles is ignored. The switch error latches in the (CLAMP_CYC+1)th consecutive cycle.
- R5: Once latched, the switch error persists until rst_n is driven low. Reset returns status to 2'b00 and sw_en to 0.
- R6: sw_en is 1 exactly when sw_cmd is 1, uv_flag is 0 and no switch error is latched. It responds in the same cycle.
- R7: Undervoltage does not latch. Status is 2'b01 while uv_flag is 1. Once uv_flag drops with no switch error latched, status returns to 2'b00 and switching resumes.
- R8: While uv_flag is 1, status reads 2'b01 even with a switch error latched. After uv_flag drops, status reads 2'b10 and sw_en stays 0.
- R9: The on-time and clamp counters restart on every new turn-on. A clamp run carried across a turn-on, or a second on-period, is measured from the new start.
- R10: Status encoding is 2'b00 normal, 2'b01 undervoltage, 2'b10 switch error, and 2'b11 never appears. The status is registered and shows its cause at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear a switch error |
| sw_cmd | input | 1 | Switch-on command |
| cmp_trip | input | 1 | Current comparator trip event |
| clamp_act | input | 1 | Overvoltage clamp is conducting |
| uv_flag | input | 1 | Undervoltage lockout condition |
| sw_en | output | 1 | Gated switch enable |
| status | output | 2 | Registered status code |

## Verification
The bench builds the block with SHORT_CYC=4, MAXON_CYC=20 and CLAMP_CYC=3. With these values every window edge can be reached in a few dozen cycles. Each limit is then probed exactly at and just past its boundary:

- a trip in on-cycle 3 versus on-cycle 4;
- 20 versus 21 enabled cycles;
- a clamp run of 3 versus 4 cycles.

The small limits also make it cheap to check counter restart across a turn-on. They also make it cheap to run the undervoltage and latched-error ordering both before and after a trip.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BLANK   = 2'd1,
        ST_ON      = 2'd2,
        ST_TRIPPED = 2'd3
    } sfp_state_e;

    typedef enum logic [1:0] {
        CODE_NORMAL    = 2'b00,
        CODE_UNDERVOLT = 2'b01,
        CODE_SWERR     = 2'b10
    } sfp_code_e;

endpackage

// File: rtl/sfp_sat_timer.sv
// Saturating up-counter. A clear reloads with the current increment,
// so a restart cycle that is also an active cycle counts as one.
module sfp_sat_timer #(
    parameter int LIMIT = 20,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? W'(1) : '0;
        end else if (inc && count != LIM) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/sfp_fsm.sv
module sfp_fsm
    import sfp_pkg::*;
#(
    parameter int SHORT_CYC = 85,
    parameter int MAXON_CYC = 5000,
    parameter int CLAMP_CYC = 20,
    localparam int OW = $clog2(MAXON_CYC + 1),
    localparam int CW = $clog2(CLAMP_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_cmd,
    input  logic          cmp_trip,
    input  logic          clamp_act,
    input  logic          uv_flag,
    input  logic [OW-1:0] on_cnt,
    input  logic [CW-1:0] clamp_cnt,
    output logic          sw_en,
    output logic          on_clr,
    output logic          new_on,
    output logic [1:0]    status
);
    localparam logic [OW-1:0] SHORT_LAST = OW'(SHORT_CYC - 1);
    localparam logic [OW-1:0] MAXON_LIM  = OW'(MAXON_CYC);
    localparam logic [CW-1:0] CLAMP_LIM  = CW'(CLAMP_CYC);
    localparam sfp_state_e    FIRST_ON   = (SHORT_CYC == 1) ? ST_ON : ST_BLANK;

    sfp_state_e state, state_nxt;
    logic       clamp_over, maxon_over;

    // Switch gating: any present fault inhibits switching
    assign sw_en  = sw_cmd && !uv_flag && (state != ST_TRIPPED);
    assign on_clr = (state == ST_IDLE);
    assign new_on = (state == ST_IDLE) && sw_en;

    // Clamp check is suppressed on the turn-on cycle (counter restarts there)
    assign clamp_over = clamp_act && !new_on && (clamp_cnt >= CLAMP_LIM);
    assign maxon_over = sw_en && (state != ST_IDLE) && (on_cnt >= MAXON_LIM);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (clamp_over)             state_nxt = ST_TRIPPED;
                else if (sw_en && cmp_trip) state_nxt = ST_TRIPPED;
                else if (sw_en)             state_nxt = FIRST_ON;
            end
            ST_BLANK: begin
                if (clamp_over || maxon_over)  state_nxt = ST_TRIPPED;
                else if (!sw_en)               state_nxt = ST_IDLE;
                else if (cmp_trip)             state_nxt = ST_TRIPPED;
                else if (on_cnt == SHORT_LAST) state_nxt = ST_ON;
            end
            ST_ON: begin
                if (clamp_over || maxon_over) state_nxt = ST_TRIPPED;
                else if (!sw_en)              state_nxt = ST_IDLE;
            end
            ST_TRIPPED: state_nxt = ST_TRIPPED;
            default:    state_nxt = ST_TRIPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output register: undervoltage dominates the latched error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       status <= CODE_NORMAL;
        else if (uv_flag)                 status <= CODE_UNDERVOLT;
        else if (state_nxt == ST_TRIPPED) status <= CODE_SWERR;
        else                              status <= CODE_NORMAL;
    end
endmodule

// File: rtl/sfp_supervisor.sv
module sfp_supervisor #(
    parameter int SHORT_CYC = 85,
    parameter int MAXON_CYC = 5000,
    parameter int CLAMP_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_cmd,
    input  logic       cmp_trip,
    input  logic       clamp_act,
    input  logic       uv_flag,
    output logic       sw_en,
    output logic [1:0] status
);
    localparam int OW = $clog2(MAXON_CYC + 1);
    localparam int CW = $clog2(CLAMP_CYC + 1);

    logic [OW-1:0] on_cnt;
    logic [CW-1:0] clamp_cnt;
    logic          on_clr, new_on;

    sfp_sat_timer #(.LIMIT(MAXON_CYC)) u_on_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (on_clr),
        .inc   (sw_en),
        .count (on_cnt)
    );

    sfp_sat_timer #(.LIMIT(CLAMP_CYC)) u_clamp_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!clamp_act || new_on),
        .inc   (clamp_act),
        .count (clamp_cnt)
    );

    sfp_fsm #(
        .SHORT_CYC (SHORT_CYC),
        .MAXON_CYC (MAXON_CYC),
        .CLAMP_CYC (CLAMP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_cmd    (sw_cmd),
        .cmp_trip  (cmp_trip),
        .clamp_act (clamp_act),
        .uv_flag   (uv_flag),
        .on_cnt    (on_cnt),
        .clamp_cnt (clamp_cnt),
        .sw_en     (sw_en),
        .on_clr    (on_clr),
        .new_on    (new_on),
        .status    (status)
    );
endmodule

// File: rtl/sfp_supervisor_chk.sv
module sfp_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_cmd,
    input logic       uv_flag,
    input logic       sw_en,
    input logic [1:0] status
);
    // R6: undervoltage always blocks the enable
    a_r6_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !sw_en);

    // R6: no enable without a command
    a_r6_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_cmd |-> !sw_en);

    // R5: latched error shown without undervoltage keeps the switch off
    a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> !sw_en);

    // R5: a reported switch error never falls back to normal without reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |=> (status != 2'b00));

    // R7: undervoltage is reported at the next edge
    a_r7_uv_code: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (status == 2'b01));

    // R10: unused code never appears
    a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);
endmodule

bind sfp_supervisor sfp_supervisor_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_cmd (sw_cmd),
    .uv_flag(uv_flag),
    .sw_en  (sw_en),
    .status (status)
);

// File: tb/tb_sfp_supervisor.sv
module tb_sfp_supervisor;
    localparam int SHORT_CYC = 4;
    localparam int MAXON_CYC = 20;
    localparam int CLAMP_CYC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_cmd = 1'b0, cmp_trip = 1'b0, clamp_act = 1'b0, uv_flag = 1'b0;
    logic       sw_en;
    logic [1:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] code;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    sfp_supervisor #(
        .SHORT_CYC (SHORT_CYC),
        .MAXON_CYC (MAXON_CYC),
        .CLAMP_CYC (CLAMP_CYC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_cmd    (sw_cmd),
        .cmp_trip  (cmp_trip),
        .clamp_act (clamp_act),
        .uv_flag   (uv_flag),
        .sw_en     (sw_en),
        .status    (status)
    );

    // Monitor: compares the registered status one edge after each step
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (status !== e.code) begin
                failures++;
                $display("FAIL %s status act=%b exp=%b", e.tag, status, e.code);
            end
        end
    end

    task automatic chk_en(input logic exp, input string tag);
        checks++;
        if (sw_en !== exp) begin
            failures++;
            $display("FAIL %s sw_en act=%b exp=%b", tag, sw_en, exp);
        end
    endtask

    // Driver: one cycle of stimulus, same-cycle enable check, queued status
    task automatic step(input logic cmd, input logic trip, input logic clmp,
                        input logic uv, input logic [1:0] exp_code,
                        input logic exp_en, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        sw_cmd = cmd; cmp_trip = trip; clamp_act = clmp; uv_flag = uv;
        #1;
        chk_en(exp_en, tag);
        e.code = exp_code;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        sw_cmd = 1'b0; cmp_trip = 1'b0; clamp_act = 1'b0; uv_flag = 1'b0;
        #1;
        checks++;
        if (status !== 2'b00) begin
            failures++;
            $display("FAIL R5 reset status act=%b exp=00", status);
        end
        chk_en(1'b0, "R5");
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        step(0, 0, 0, 0, 2'b00, 0, "R10");

        // R2 / R6: normal pulse, trip at on-cycle SHORT_CYC is benign
        for (int k = 0; k < 8; k++)
            step(1, k == SHORT_CYC, 0, 0, 2'b00, 1, "R2");
        step(0, 0, 0, 0, 2'b00, 0, "R6");

        // R1: trip at on-cycle SHORT_CYC-1 latches error
        for (int k = 0; k < SHORT_CYC - 1; k++)
            step(1, 0, 0, 0, 2'b00, 1, "R1");
        step(1, 1, 0, 0, 2'b10, 1, "R1");
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 0, 2'b10, 0, "R5");
        step(0, 0, 0, 0, 2'b10, 0, "R5");
        do_reset();

        // R1: trip in the very first on-cycle
        step(1, 1, 0, 0, 2'b10, 1, "R1");
        do_reset();

        // R3: exactly MAXON_CYC cycles on is accepted
        for (int k = 0; k < MAXON_CYC; k++)
            step(1, 0, 0, 0, 2'b00, 1, "R3");
        step(0, 0, 0, 0, 2'b00, 0, "R3");
        // R3: one more cycle latches
        for (int k = 0; k < MAXON_CYC; k++)
            step(1, 0, 0, 0, 2'b00, 1, "R3");
        step(1, 0, 0, 0, 2'b10, 1, "R3");
        step(1, 0, 0, 0, 2'b10, 0, "R3");
        do_reset();

        // R9: on-timer restarts after a gap
        for (int k = 0; k < 15; k++)
            step(1, 0, 0, 0, 2'b00, 1, "R9");
        step(0, 0, 0, 0, 2'b00, 0, "R9");
        for (int k = 0; k < 15; k++)
            step(1, 0, 0, 0, 2'b00, 1, "R9");
        step(0, 0, 0, 0, 2'b00, 0, "R9");

        // R4: clamp run of CLAMP_CYC cycles ignored
        for (int k = 0; k < CLAMP_CYC; k++)
            step(0, 0, 1, 0, 2'b00, 0, "R4");
        step(0, 0, 0, 0, 2'b00, 0, "R4");

        // R9: clamp run carried into a turn-on restarts there
        for (int k = 0; k < CLAMP_CYC; k++)
            step(0, 0, 1, 0, 2'b00, 0, "R9");
        step(1, 0, 1, 0, 2'b00, 1, "R9");
        step(1, 0, 0, 0, 2'b00, 1, "R9");
        step(0, 0, 0, 0, 2'b00, 0, "R9");

        // R4: clamp run of CLAMP_CYC+1 cycles latches
        for (int k = 0; k < CLAMP_CYC; k++)
            step(0, 0, 1, 0, 2'b00, 0, "R4");
        step(0, 0, 1, 0, 2'b10, 0, "R4");
        step(1, 0, 0, 0, 2'b10, 0, "R4");
        do_reset();

        // R7: undervoltage is non-latching
        step(1, 0, 0, 1, 2'b01, 0, "R7");
        step(1, 0, 0, 1, 2'b01, 0, "R7");
        step(1, 0, 0, 0, 2'b00, 1, "R7");
        step(0, 0, 0, 0, 2'b00, 0, "R7");

        // R8: undervoltage masks a latched error, error reappears after
        step(1, 1, 0, 0, 2'b10, 1, "R8");
        step(1, 0, 0, 1, 2'b01, 0, "R8");
        step(1, 0, 0, 1, 2'b01, 0, "R8");
        step(1, 0, 0, 0, 2'b10, 0, "R8");
        step(0, 0, 0, 0, 2'b10, 0, "R8");
        do_reset();
        step(1, 0, 0, 0, 2'b00, 1, "R5");
        step(0, 0, 0, 0, 2'b00, 0, "R10");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule